// File: doc/BRIEF.md
# Asynchronous Edge Interval Timer

The block measures the interval between a rising edge on a start input and a later rising edge on a stop input. It counts cycles of a fast local clock, and neither input is related to that clock. Each input passes through a two-flop synchronizer and then a rising-edge detector. A synchronized start edge zeroes the counter and arms the timer. A synchronized stop edge, while the timer is armed, copies the count into a capture register, raises a sticky completion flag and disarms the timer.

Software polls a status word through a small read port and then fetches the captured count. Because the stop input is synchronized, a status read always returns on time, whatever the phase of the input edges. The synchronizers add the same fixed latency to both edges, so a start and a stop that are D clock cycles apart produce a capture of D. A counter that runs past its range holds at all ones and raises an overflow flag.

Top module: `edge_interval_timer`

## Requirements
- R1: After reset, the status word reads 0, the capture register reads 0 and `rd_valid` is low.
- R2: A rising edge on `start_in` sets the running bit (status bit 2) three clock edges later, and the count starts again from zero.
- R3: If the stop rising edge is registered D clock edges after the start rising edge (1 ≤ D < 2^CNT_W), the captured value is D. Capture clears the running bit.
- R4: A capture sets the done bit (status bit 0). The bit stays set until software reads the status word.
- R5: A status read returns the flags as they were before the read, then clears done and overflow. A capture or saturation in the same cycle as the read wins, and its flag stays set.
- R6: The count saturates at 2^CNT_W−1. An increment attempted at that value sets the overflow bit (status bit 1). For D ≥ 2^CNT_W, the captured value is 2^CNT_W−1.
- R7: A stop edge while the timer is not running is ignored. Done stays clear and the capture register keeps its value.
- R8: A start edge while running restarts the measurement from zero. The captured value does not change except on a capture.
- R9: `rd_addr`=0 selects the status word (zero-extended) and `rd_addr`=1 selects the capture register. `rd_data` and `rd_valid` appear one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_in | input | 1 | Asynchronous start edge input |
| stop_in | input | 1 | Asynchronous stop edge input |
| rd_en | input | 1 | Read strobe, one cycle |
| rd_addr | input | 1 | Register select: 0 status, 1 capture |
| rd_data | output | CNT_W | Read data, valid one cycle after the strobe |
| rd_valid | output | 1 | Marks the cycle in which rd_data holds read data |

## Verification
The assertions assume that `rd_en` is a synchronous strobe. They also assume that each input edge is held for at least one clock edge, so the synchronizers register it. No assertion depends on the phase of the inputs relative to the clock. The stimulus changes every input on the falling clock edge and holds each pulse for a full cycle. That puts the start-to-stop spacing at an exact whole number of cycles, so the expected capture can be computed as min(D, 2^CNT_W−1). A sweep of D past the saturation point, on a 6-bit counter, covers both the exact and the saturated results.

// File: rtl/eit_pkg.sv
`timescale 1ns/1ps
package eit_pkg;
  typedef enum logic {REG_STATUS = 1'b0, REG_CAPTURE = 1'b1} reg_sel_e;
  localparam int unsigned BIT_DONE = 0;
  localparam int unsigned BIT_OVF  = 1;
  localparam int unsigned BIT_RUN  = 2;
  localparam int unsigned STAT_W   = 3;
endpackage

// File: rtl/eit_sync.sv
`timescale 1ns/1ps
module eit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ff <= '0;
        else        ff <= d_async;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ff <= '0;
        else        ff <= {ff[STAGES-2:0], d_async};
    end
  endgenerate

  assign q_sync = ff[STAGES-1];
endmodule

// File: rtl/eit_rise.sv
`timescale 1ns/1ps
module eit_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;

  assign rise = lvl & ~lvl_d;

  // R2: a detected edge lasts exactly one cycle
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/eit_counter.sv
`timescale 1ns/1ps
module eit_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         run_en,
  output logic [W-1:0] cnt_next,
  output logic         sat_hit
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt;

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (v == CNT_MAX) ? CNT_MAX : v + 1'b1;
  endfunction

  always_comb begin
    if (clear)       cnt_next = '0;
    else if (run_en) cnt_next = sat_inc(cnt);
    else             cnt_next = cnt;
  end

  assign sat_hit = run_en & ~clear & (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_next;

  // R6: count holds at all ones while running
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && run_en && !clear) |=> (cnt == CNT_MAX));
  // R2: a start clears the count
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));
  // R7: an idle counter does not move
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !clear) |=> $stable(cnt));
endmodule

// File: rtl/eit_regs.sv
`timescale 1ns/1ps
module eit_regs
  import eit_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_evt,
  input  logic [W-1:0] cap_val,
  input  logic         sat_hit,
  input  logic         running,
  input  logic         rd_en,
  input  logic         rd_addr,
  output logic [W-1:0] rd_data,
  output logic         rd_valid
);
  logic [W-1:0] cap_q;
  logic         done_q, ovf_q;
  logic         stat_rd;
  logic [W-1:0] stat_word;

  assign stat_rd = rd_en & (rd_addr == REG_STATUS);

  always_comb begin
    stat_word = '0;
    stat_word[BIT_DONE] = done_q;
    stat_word[BIT_OVF]  = ovf_q;
    stat_word[BIT_RUN]  = running;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q    <= '0;
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (cap_evt) cap_q <= cap_val;
      if (cap_evt)      done_q <= 1'b1;
      else if (stat_rd) done_q <= 1'b0;
      if (sat_hit)      ovf_q <= 1'b1;
      else if (stat_rd) ovf_q <= 1'b0;
      rd_valid <= rd_en;
      if (rd_en) rd_data <= (rd_addr == REG_CAPTURE) ? cap_q : stat_word;
    end
  end

  // R8: capture register moves only on a capture
  cap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_q));
  // R4: capture raises done
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> done_q);
  // R5: a status read with no capture clears done
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !cap_evt) |=> !done_q);
  // R9: one-cycle read latency
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

// File: rtl/edge_interval_timer.sv
`timescale 1ns/1ps
module edge_interval_timer #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_in,
  input  logic             stop_in,
  input  logic             rd_en,
  input  logic             rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             rd_valid
);
  logic start_s, stop_s;
  logic start_rise, stop_rise;
  logic running;
  logic cap_evt;
  logic sat_hit;
  logic [CNT_W-1:0] cnt_next;

  eit_sync #(.STAGES(SYNC_STAGES)) u_sync_start (
    .clk(clk), .rst_n(rst_n), .d_async(start_in), .q_sync(start_s));
  eit_sync #(.STAGES(SYNC_STAGES)) u_sync_stop (
    .clk(clk), .rst_n(rst_n), .d_async(stop_in), .q_sync(stop_s));

  eit_rise u_rise_start (.clk(clk), .rst_n(rst_n), .lvl(start_s), .rise(start_rise));
  eit_rise u_rise_stop  (.clk(clk), .rst_n(rst_n), .lvl(stop_s),  .rise(stop_rise));

  // start wins over a coincident stop
  assign cap_evt = stop_rise & running & ~start_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          running <= 1'b0;
    else if (start_rise) running <= 1'b1;
    else if (cap_evt)    running <= 1'b0;

  eit_counter #(.W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .clear(start_rise), .run_en(running),
    .cnt_next(cnt_next), .sat_hit(sat_hit));

  eit_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .cap_val(cnt_next),
    .sat_hit(sat_hit), .running(running), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid));

  // R7: a stop edge while idle never captures
  idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_rise && !running) |-> !cap_evt);
  // R3: a capture ends the run
  cap_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> !running);
  // R2: a start arms the timer
  start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise |=> running);
endmodule

// File: tb/edge_interval_timer_bench.sv
`timescale 1ns/1ps
module edge_interval_timer_bench;
  localparam int W    = 6;
  localparam int CMAX = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_in = 1'b0, stop_in = 1'b0, rd_en = 1'b0, rd_addr = 1'b0;
  logic [W-1:0] rd_data;
  logic rd_valid;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  edge_interval_timer #(.CNT_W(W)) u_edge_interval_timer (
    .clk(clk), .rst_n(rst_n), .start_in(start_in), .stop_in(stop_in),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid));

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output int val);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(int'(rd_valid), 1, "R9 rd_valid");
    val = int'(rd_data);
  endtask

  function automatic int stat(input bit done, input bit ovf, input bit run);
    return int'(done) | (int'(ovf) << 1) | (int'(run) << 2);
  endfunction

  // start at step 0, optional restart, stop at step d, optional colliding read
  task automatic meas(input int d, input int restart_at, input bit collide, input bit probe);
    int v;
    for (int i = 0; i <= d + 8; i++) begin
      @(negedge clk);
      if (probe && i == 6) chk(int'(rd_data), stat(0, 0, 1), "R2 running bit");
      if (collide && i == d + 3) chk(int'(rd_data), stat(0, 0, 1), "R5 read during capture");
      start_in = (i == 0) || (i == restart_at);
      stop_in  = (i == d);
      rd_en    = (probe && i == 5) || (collide && i == d + 2);
      rd_addr  = 1'b0;
    end
    rd(1'b0, v);
  endtask

  initial begin
    int v, exp_cap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(rd_valid), 0, "R1 rd_valid at reset");
    rd(1'b0, v); chk(v, 0, "R1 status at reset");
    rd(1'b1, v); chk(v, 0, "R1 capture at reset");

    // sweep across the saturation point
    for (int d = 1; d <= CMAX + 6; d++) begin
      meas(d, -1, 0, d >= 10);
      chk(int'(rd_data), stat(1, d > CMAX, 0), "R3 R4 R6 status after capture");
      exp_cap = (d > CMAX) ? CMAX : d;
      rd(1'b1, v); chk(v, exp_cap, "R3 R6 captured count");
      rd(1'b0, v); chk(v, 0, "R5 status cleared by read");
    end

    // stop while idle
    @(negedge clk); stop_in = 1'b1;
    @(negedge clk); stop_in = 1'b0;
    repeat (6) @(negedge clk);
    rd(1'b0, v); chk(v, 0, "R7 idle stop no done");
    rd(1'b1, v); chk(v, CMAX, "R7 idle stop capture kept");

    // restart while running
    meas(25, 10, 0, 0);
    chk(int'(rd_data), stat(1, 0, 0), "R8 restart status");
    rd(1'b1, v); chk(v, 15, "R8 restart measures from second start");
    rd(1'b1, v); chk(v, 15, "R8 capture stable");

    // status read in the capture cycle
    rd(1'b0, v);
    meas(20, -1, 1, 0);
    chk(int'(rd_data), stat(1, 0, 0), "R5 capture wins over read");
    rd(1'b1, v); chk(v, 20, "R5 capture value");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule